// File: doc/BRIEF.md
# Correlating Two-Level Branch Direction Predictor

This block guesses whether a conditional branch will be taken. The branch address picks a row of a small table. Each row holds one 2-bit saturating counter for every pattern of the last two branch outcomes seen anywhere in the program. A global history register holds those outcomes and chooses which counter in the row gives the guess. The same counter is later trained. A branch therefore gets its own behaviour for each recent path, instead of one blended counter.

The fetch stage presents a PC on the lookup port. The guess and the history value in use come back combinationally in the same cycle. When the branch resolves, the back end returns the branch PC, the real outcome and the history value it was given at lookup. The predictor trains the one counter those values name. It then shifts the outcome into the global history. The table depth is set by a parameter.

Top module: `corr_bpred`

## Requirements
- R1: After reset every counter holds 01 (weakly not taken) and the global history is 00, so every lookup returns not taken with `lk_hist` = 00.
- R2: `lk_taken` is the upper bit of the counter chosen by the lookup row and the current history. Counter values 10 and 11 predict taken, and 00 and 01 predict not taken. The result appears in the same cycle the PC is presented.
- R3: A taken update raises the chosen counter by one and stops at 11.
- R4: A not-taken update lowers the chosen counter by one and stops at 00.
- R5: A counter at 11 still predicts taken after one not-taken update and predicts not taken after a second. The mirror case holds from 00.
- R6: Each update moves the history left by one place and puts the new outcome in bit 0. `lk_hist` shows the history value that the current lookup uses.
- R7: The row index is PC[INDEX_BITS+1:2]. PC bits 1:0 and all bits above the index do not affect the row chosen.
- R8: An update changes only the counter named by the row of `upd_pc` and by `upd_hist`. The other counters in that row and all other rows keep their values.
- R9: A lookup made in the same cycle as an update sees the counter value from before that update.
- R10: With `upd_valid` low, no counter and no history bit changes, whatever is on the other update inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_pc | input | PC_W | PC of the branch being predicted |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| lk_hist | output | HIST_W | Global history value used for this lookup |
| upd_valid | input | 1 | A resolved branch is presented for training |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Actual outcome, 1 = taken |
| upd_hist | input | HIST_W | History value returned with the branch at lookup time |

## Verification
The hardest state to reach from the ports is one where a counter in a chosen row and history slot sits at a set value while the global history points at it. Every training step also moves the history. The bench first trains the target counter using an explicit `upd_hist` value. It then steers the global history back to that slot by sending two updates to a spare row, with outcomes that spell out the wanted history bits. After that it reads the prediction. A reference model in the bench follows every counter, including the spare row, so the spare-row training does not hide an error.

// File: rtl/bp_pkg.sv
package bp_pkg;

  // Width of one direction counter.
  localparam int CTR_W = 2;

  typedef logic [CTR_W-1:0] ctr_t;

  localparam ctr_t CTR_MIN  = '0;
  localparam ctr_t CTR_MAX  = '1;
  // Weakly not taken: one step below the taken half.
  localparam ctr_t CTR_INIT = ctr_t'((1 << (CTR_W - 1)) - 1);

  // Saturating step: up on taken, down on not taken.
  function automatic ctr_t ctr_step(input ctr_t c, input logic up);
    ctr_t r;
    if (up) r = (c == CTR_MAX) ? c : c + ctr_t'(1);
    else    r = (c == CTR_MIN) ? c : c - ctr_t'(1);
    return r;
  endfunction

  // Direction is the top bit of the counter.
  function automatic logic ctr_dir(input ctr_t c);
    return c[CTR_W-1];
  endfunction

endpackage

// File: rtl/bp_sat_ctr.sv
module bp_sat_ctr
  import bp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic we,
  input  logic up,
  output ctr_t q
);

  ctr_t q_r;
  ctr_t q_next;

  assign q_next = ctr_step(q_r, up);
  assign q      = q_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_r <= CTR_INIT;
    else if (we) q_r <= q_next;
  end

  AST_CTR_RESET_INIT: assert property (@(posedge clk) !rst_n |=> q == CTR_INIT); // R1
  AST_CTR_INC: assert property (@(posedge clk) disable iff (!rst_n)
    we && up && (q != CTR_MAX) |=> q == ctr_t'($past(q) + ctr_t'(1))); // R3
  AST_CTR_TOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    we && up && (q == CTR_MAX) |=> q == CTR_MAX); // R3
  AST_CTR_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    we && !up && (q != CTR_MIN) |=> q == ctr_t'($past(q) - ctr_t'(1))); // R4
  AST_CTR_BOTTOM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    we && !up && (q == CTR_MIN) |=> q == CTR_MIN); // R4
  AST_CTR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q)); // R8

endmodule

// File: rtl/bp_hist.sv
module bp_hist #(
  parameter int HIST_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              new_bit,
  output logic [HIST_W-1:0] hist_q
);

  logic [HIST_W-1:0] hist_r;
  logic [HIST_W-1:0] hist_next;

  assign hist_next = {hist_r[HIST_W-2:0], new_bit};
  assign hist_q    = hist_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hist_r <= '0;
    else if (shift_en) hist_r <= hist_next;
  end

  AST_HIST_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> hist_q[0] == $past(new_bit)); // R6
  AST_HIST_AGE: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> hist_q[HIST_W-1:1] == $past(hist_q[HIST_W-2:0])); // R6
  AST_HIST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(hist_q)); // R10

endmodule

// File: rtl/bp_table.sv
module bp_table
  import bp_pkg::*;
#(
  parameter int INDEX_BITS = 4,
  parameter int HIST_W     = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [INDEX_BITS-1:0] rd_idx,
  input  logic [HIST_W-1:0]     rd_way,
  output ctr_t                  rd_ctr,
  input  logic                  wr_en,
  input  logic [INDEX_BITS-1:0] wr_idx,
  input  logic [HIST_W-1:0]     wr_way,
  input  logic                  wr_up
);

  localparam int DEPTH = 1 << INDEX_BITS;
  localparam int WAYS  = 1 << HIST_W;
  localparam int NCTR  = DEPTH * WAYS;
  localparam int SEL_W = INDEX_BITS + HIST_W;

  logic [SEL_W-1:0] rd_sel;
  logic [SEL_W-1:0] wr_sel;
  logic [NCTR-1:0]  cell_we;
  ctr_t             cell_q [NCTR];

  assign rd_sel = {rd_idx, rd_way};
  assign wr_sel = {wr_idx, wr_way};

  for (genvar g = 0; g < NCTR; g++) begin : g_cell
    assign cell_we[g] = wr_en && (wr_sel == SEL_W'(g));
    bp_sat_ctr u_cell (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cell_we[g]),
      .up    (wr_up),
      .q     (cell_q[g])
    );
  end

  // Read comes from the registers, so a same-cycle write is not yet visible.
  assign rd_ctr = cell_q[rd_sel];

  AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cell_we)); // R8
  AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |-> cell_we == '0); // R10

endmodule

// File: rtl/corr_bpred.sv
module corr_bpred
  import bp_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int INDEX_BITS = 4,
  parameter int HIST_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   lk_pc,
  output logic              lk_taken,
  output logic [HIST_W-1:0] lk_hist,
  input  logic              upd_valid,
  input  logic [PC_W-1:0]   upd_pc,
  input  logic              upd_taken,
  input  logic [HIST_W-1:0] upd_hist
);

  localparam int IDX_LO = 2;
  localparam int IDX_HI = INDEX_BITS + IDX_LO - 1;

  logic [INDEX_BITS-1:0] lk_idx;
  logic [INDEX_BITS-1:0] upd_idx;
  logic [HIST_W-1:0]     ghist;
  ctr_t                  lk_ctr;

  // Byte offset and upper PC bits do not take part in indexing.
  logic unused_pc_bits;
  assign unused_pc_bits = ^{lk_pc[PC_W-1:IDX_HI+1], lk_pc[IDX_LO-1:0],
                            upd_pc[PC_W-1:IDX_HI+1], upd_pc[IDX_LO-1:0]};

  assign lk_idx  = lk_pc[IDX_HI:IDX_LO];
  assign upd_idx = upd_pc[IDX_HI:IDX_LO];

  bp_hist #(.HIST_W(HIST_W)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (upd_valid),
    .new_bit  (upd_taken),
    .hist_q   (ghist)
  );

  bp_table #(.INDEX_BITS(INDEX_BITS), .HIST_W(HIST_W)) u_table (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_idx (lk_idx),
    .rd_way (ghist),
    .rd_ctr (lk_ctr),
    .wr_en  (upd_valid),
    .wr_idx (upd_idx),
    .wr_way (upd_hist),
    .wr_up  (upd_taken)
  );

  assign lk_taken = ctr_dir(lk_ctr);
  assign lk_hist  = ghist;

  AST_HIST_RESET: assert property (@(posedge clk) !rst_n |=> lk_hist == '0); // R1
  AST_LOOKUP_NOT_TAKEN_AT_RESET: assert property (@(posedge clk)
    !rst_n |=> !lk_taken); // R1

endmodule

// File: tb/corr_bpred_test.sv
`timescale 1ns/1ps
module corr_bpred_test;

  localparam int PC_W  = 32;
  localparam int IB    = 4;
  localparam int HW    = 2;
  localparam int DEPTH = 1 << IB;
  localparam int WAYS  = 1 << HW;
  localparam logic [31:0] SCRATCH = 32'h0000_003C; // row 15

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [PC_W-1:0] lk_pc = '0;
  logic            lk_taken;
  logic [HW-1:0]   lk_hist;
  logic            upd_valid = 1'b0;
  logic [PC_W-1:0] upd_pc = '0;
  logic            upd_taken = 1'b0;
  logic [HW-1:0]   upd_hist = '0;

  int checks = 0;
  int fails  = 0;

  // Reference model
  int          m_ctr [DEPTH*WAYS];
  logic [1:0]  m_hist;

  always #2.5 clk = ~clk;

  corr_bpred #(.PC_W(PC_W), .INDEX_BITS(IB), .HIST_W(HW)) uut (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
    .lk_hist(lk_hist), .upd_valid(upd_valid), .upd_pc(upd_pc),
    .upd_taken(upd_taken), .upd_hist(upd_hist)
  );

  function automatic int row_of(input logic [31:0] pc);
    return int'((pc / 4) % DEPTH);
  endfunction

  function automatic logic exp_pred(input logic [31:0] pc);
    return m_ctr[row_of(pc)*WAYS + int'(m_hist)] > 1;
  endfunction

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic check_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic model_train(input logic [31:0] pc, input logic t, input logic [1:0] h);
    int k;
    k = row_of(pc)*WAYS + int'(h);
    if (t) m_ctr[k] = (m_ctr[k] == 3) ? 3 : m_ctr[k] + 1;
    else   m_ctr[k] = (m_ctr[k] == 0) ? 0 : m_ctr[k] - 1;
    m_hist = {m_hist[0], t};
  endtask

  task automatic update(input logic [31:0] pc, input logic t, input logic [1:0] h);
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = pc; upd_taken = t; upd_hist = h;
    @(posedge clk);
    model_train(pc, t, h);
    #1 upd_valid = 1'b0;
  endtask

  task automatic update_here(input logic [31:0] pc, input logic t);
    update(pc, t, m_hist);
  endtask

  task automatic set_hist(input logic [1:0] h);
    update_here(SCRATCH, h[1]);
    update_here(SCRATCH, h[0]);
  endtask

  task automatic probe(input logic [31:0] pc, input string req);
    @(negedge clk);
    lk_pc = pc;
    #1;
    check_bit(req, lk_taken, exp_pred(pc));
    checks++;
    if (lk_hist !== m_hist) begin
      fails++;
      $display("FAIL %s hist: actual %0b expected %0b", req, lk_hist, m_hist);
    end
  endtask

  task automatic t_reset;
    probe(32'h0000_0000, "R1");
    probe(32'h0000_0024, "R1");
    probe(32'hFFFF_FFFC, "R1");
  endtask

  task automatic t_count_up;
    // row 1 slot 3: +1 makes 10, predicts taken (R2, R3)
    update(32'h4, 1'b1, 2'b11);
    set_hist(2'b11);
    probe(32'h4, "R2");
    check_bit("R3", lk_taken, 1'b1);
    repeat (4) update(32'h4, 1'b1, 2'b11);
    // saturated at 11: one down leaves 10 -> still taken
    update(32'h4, 1'b0, 2'b11);
    set_hist(2'b11);
    probe(32'h4, "R3");
    check_bit("R3", lk_taken, 1'b1);
  endtask

  task automatic t_count_down;
    repeat (5) update(32'h8, 1'b0, 2'b01);
    update(32'h8, 1'b1, 2'b01); // 00 -> 01
    set_hist(2'b01);
    probe(32'h8, "R4");
    check_bit("R4", lk_taken, 1'b0);
    update(32'h8, 1'b1, 2'b01); // 01 -> 10
    set_hist(2'b01);
    probe(32'h8, "R4");
    check_bit("R4", lk_taken, 1'b1);
  endtask

  task automatic t_hysteresis;
    repeat (3) update(32'hC, 1'b1, 2'b10);
    update(32'hC, 1'b0, 2'b10);
    set_hist(2'b10);
    probe(32'hC, "R5");
    check_bit("R5", lk_taken, 1'b1);
    update(32'hC, 1'b0, 2'b10);
    set_hist(2'b10);
    probe(32'hC, "R5");
    check_bit("R5", lk_taken, 1'b0);
  endtask

  task automatic t_history;
    logic [3:0] pat;
    pat = 4'b1011;
    for (int i = 3; i >= 0; i--) begin
      update_here(SCRATCH, pat[i]);
      probe(32'h10, "R6");
    end
    check_bit("R6", lk_hist[0], 1'b1);
    check_bit("R6", lk_hist[1], 1'b1);
  endtask

  task automatic t_index;
    set_hist(2'b00);
    update(32'h0000_0018, 1'b1, 2'b00); // row 6
    set_hist(2'b00);
    probe(32'hABC0_001B, "R7");
    check_bit("R7", lk_taken, 1'b1);
    probe(32'h0000_001C, "R7");
    check_bit("R7", lk_taken, 1'b0);
  endtask

  task automatic t_isolation;
    update(32'h2C, 1'b1, 2'b10); // row 11 slot 2
    for (int w = 0; w < WAYS; w++) begin
      set_hist(w[1:0]);
      probe(32'h2C, "R8");
      check_bit("R8", lk_taken, (w == 2));
      probe(32'h30, "R8");
      check_bit("R8", lk_taken, 1'b0);
    end
  endtask

  task automatic t_same_cycle;
    set_hist(2'b00);
    @(negedge clk);
    lk_pc = 32'h14; // row 5 slot 0 at 01
    upd_valid = 1'b1; upd_pc = 32'h14; upd_taken = 1'b1; upd_hist = 2'b00;
    #1;
    check_bit("R9", lk_taken, 1'b0);
    @(posedge clk);
    model_train(32'h14, 1'b1, 2'b00);
    #1 upd_valid = 1'b0;
    set_hist(2'b00);
    probe(32'h14, "R9");
    check_bit("R9", lk_taken, 1'b1);
  endtask

  task automatic t_idle;
    logic [1:0] h0;
    set_hist(2'b10);
    h0 = m_hist;
    @(negedge clk);
    upd_pc = 32'hC; upd_hist = 2'b10;
    for (int i = 0; i < 6; i++) begin
      upd_taken = i[0];
      @(negedge clk);
    end
    probe(32'hC, "R10");
    check_bit("R10", lk_hist[0], h0[0]);
    check_bit("R10", lk_hist[1], h0[1]);
  endtask

  initial begin
    #200000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual hung expected done");
    report();
  end

  initial begin
    for (int i = 0; i < DEPTH*WAYS; i++) m_ctr[i] = 1;
    m_hist = 2'b00;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_count_up();
    t_count_down();
    t_hysteresis();
    t_history();
    t_index();
    t_isolation();
    t_same_cycle();
    t_idle();
    report();
  end

endmodule